// File: doc/BRIEF.md
# Binned Strict-Priority Round-Robin Channel Scheduler

This block decides which receive channel gets the next service slot on a shared receive DMA engine. Every channel carries a 2-bit priority code, and that code places the channel in one of four bins. Bins are served in strict order. Inside a bin the channels take turns in a fixed circular order. A channel is a candidate only while it is enabled and its per-channel buffer reports enough free space.

The engine pulses a request strobe when it can take more work. One clock later the scheduler returns a one-hot grant across all channels, together with a valid flag. Each bin keeps its own rotation pointer, and a bin's pointer moves only when that bin supplies the winner. The channel count is a parameter. The block moves no data, holds no FIFO and decodes no registers.

Top module: `rx_bin_sched`

## Requirements
- R1: After reset, grant_valid is low, the grant vector is all zeros and every bin's rotation pointer is at channel 0, so the first grant in each bin goes to its lowest-index candidate.
- R2: The priority code of channel c sits in ch_prio[2c+1:2c]. Code 0 is the highest bin, 1 is medium-high, 2 is medium-low and 3 is the lowest bin.
- R3: If any candidate exists in a higher bin, the grant always goes to a channel in the highest non-empty bin.
- R4: A channel is a candidate only when both its ch_enable bit and its ch_space_ok bit are 1. A channel missing either bit is never granted.
- R5: Inside a bin, the grant goes to the first candidate found at or after that bin's pointer, searching upward and wrapping. After a grant, that bin's pointer moves to the slot just after the granted channel, wrapping at NUM_CH.
- R6: A grant from one bin leaves the pointers of the other three bins unchanged.
- R7: grant_valid and the grant appear in the cycle after the clock edge that samples req_strobe high, and they last for that one cycle. With no strobe, grant_valid is 0 and the grant is all zeros.
- R8: A strobe that finds no candidate gives grant_valid 0 and a zero grant, and no pointer moves.
- R9: While grant_valid is 1, exactly one bit of the grant is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_space_ok | input | NUM_CH | Per-channel flag: the buffer has enough free space |
| ch_prio | input | 2*NUM_CH | Per-channel 2-bit bin code |
| req_strobe | input | 1 | The engine asks for the next service slot |
| grant | output | NUM_CH | One-hot grant to the winning channel |
| grant_valid | output | 1 | The grant is valid this cycle |

## Verification
Strict pre-emption and circular rotation can fall in the same cycle. A higher bin takes the grant while a lower bin holds candidates, and the lower bin's pointer must then stay where it was. Random stimulus mixes priority codes on every strobe so that bins keep winning and losing against each other. Directed sequences then return to a bin that was pre-empted. A bench model keeps its own four pointers and predicts every grant, so a pointer that moves when it should not shows up as a wrong channel later on.

// File: rtl/rx_sched_pkg.sv
package rx_sched_pkg;
    localparam int PRIO_W   = 2;
    localparam int NUM_BINS = 4;

    typedef enum logic [PRIO_W-1:0] {
        BIN_HIGH  = 2'd0,
        BIN_MHIGH = 2'd1,
        BIN_MLOW  = 2'd2,
        BIN_LOW   = 2'd3
    } bin_e;
endpackage

// File: rtl/rx_bin_mask.sv
// Splits the channels into per-bin candidate masks (R2, R4).
module rx_bin_mask
    import rx_sched_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH-1:0]                   en,
    input  logic [NUM_CH-1:0]                   space_ok,
    input  logic [PRIO_W*NUM_CH-1:0]            prio,
    output logic [NUM_BINS-1:0][NUM_CH-1:0]     bin_mask
);
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign bin_mask[b][c] = en[c] & space_ok[c] &
                                    (prio[c*PRIO_W +: PRIO_W] == PRIO_W'(b));
        end
    end
endmodule

// File: rtl/rx_rr_pick.sv
// Circular search from a pointer: returns the first set mask bit and the slot after it (R5).
module rx_rr_pick #(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [IDX_W-1:0]  ptr,
    output logic              found,
    output logic [IDX_W-1:0]  pick_idx,
    output logic [IDX_W-1:0]  next_ptr
);
    localparam int CW = IDX_W + 1;
    logic [CW-1:0] cand;

    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        cand     = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            cand = {1'b0, ptr} + CW'(k);
            if (cand >= CW'(NUM_CH)) begin
                cand = cand - CW'(NUM_CH);
            end
            if (!found && mask[cand[IDX_W-1:0]]) begin
                found    = 1'b1;
                pick_idx = cand[IDX_W-1:0];
            end
        end
        if (pick_idx == IDX_W'(NUM_CH-1)) begin
            next_ptr = '0;
        end else begin
            next_ptr = pick_idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/rx_bin_select.sv
// Strict order across bins: the lowest-numbered non-empty bin wins (R3).
module rx_bin_select
    import rx_sched_pkg::*;
(
    input  logic [NUM_BINS-1:0] bin_any,
    output logic                sel_valid,
    output logic [PRIO_W-1:0]   sel_bin
);
    always_comb begin
        sel_valid = 1'b0;
        sel_bin   = '0;
        for (int b = NUM_BINS - 1; b >= 0; b--) begin
            if (bin_any[b]) begin
                sel_valid = 1'b1;
                sel_bin   = PRIO_W'(b);
            end
        end
    end
endmodule

// File: rtl/rx_bin_sched.sv
module rx_bin_sched
    import rx_sched_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         ch_enable,
    input  logic [NUM_CH-1:0]         ch_space_ok,
    input  logic [PRIO_W*NUM_CH-1:0]  ch_prio,
    input  logic                      req_strobe,
    output logic [NUM_CH-1:0]         grant,
    output logic                      grant_valid
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [NUM_BINS-1:0][IDX_W-1:0] ptr;
        logic [NUM_CH-1:0]              grant;
        logic                           valid;
    } sched_state_t;

    sched_state_t state_d, state_q;

    logic [NUM_BINS-1:0][NUM_CH-1:0] bin_mask;
    logic [NUM_BINS-1:0]             bin_any;
    logic [NUM_BINS-1:0][IDX_W-1:0]  pick_idx;
    logic [NUM_BINS-1:0][IDX_W-1:0]  pick_next;
    logic                            sel_valid;
    logic [PRIO_W-1:0]               sel_bin;

    rx_bin_mask #(.NUM_CH(NUM_CH)) u_mask (
        .en       (ch_enable),
        .space_ok (ch_space_ok),
        .prio     (ch_prio),
        .bin_mask (bin_mask)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_rr
        rx_rr_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
            .mask     (bin_mask[b]),
            .ptr      (state_q.ptr[b]),
            .found    (bin_any[b]),
            .pick_idx (pick_idx[b]),
            .next_ptr (pick_next[b])
        );
    end

    rx_bin_select u_sel (
        .bin_any   (bin_any),
        .sel_valid (sel_valid),
        .sel_bin   (sel_bin)
    );

    always_comb begin
        state_d       = state_q;
        state_d.grant = '0;
        state_d.valid = 1'b0;
        if (req_strobe && sel_valid) begin
            state_d.valid        = 1'b1;
            state_d.grant        = NUM_CH'(1) << pick_idx[sel_bin];
            state_d.ptr[sel_bin] = pick_next[sel_bin];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign grant       = state_q.grant;
    assign grant_valid = state_q.valid;

    // R9
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $onehot(grant));
    // R7
    a_r7_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past(req_strobe));
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant == '0));
    // R4
    a_r4_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((grant & $past(ch_enable & ch_space_ok)) != '0));
    // R3
    a_r3_top_bin: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($past(bin_mask[0]) == '0) || ((grant & $past(bin_mask[0])) != '0)));
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_strobe && (bin_any == '0)) |=> ($stable(state_q.ptr) && !grant_valid));
endmodule

// File: tb/rx_bin_sched_bench.sv
module rx_bin_sched_bench;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ch_enable = '0;
    logic [N-1:0]    ch_space_ok = '0;
    logic [2*N-1:0]  ch_prio = '0;
    logic            req_strobe = 1'b0;
    logic [N-1:0]    grant;
    logic            grant_valid;

    int checks = 0;
    int errors = 0;
    int mptr [4];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_bin_sched #(.NUM_CH(N)) u_rx_bin_sched (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_space_ok(ch_space_ok),
        .ch_prio(ch_prio), .req_strobe(req_strobe), .grant(grant), .grant_valid(grant_valid)
    );

    // Reference: bin order then circular search; updates the model pointers.
    function automatic void predict(input logic [N-1:0] en, input logic [N-1:0] sp,
                                    input logic [2*N-1:0] pr, input bit upd,
                                    output logic [N-1:0] g, output logic v);
        g = '0; v = 1'b0;
        for (int b = 0; b < 4 && !v; b++) begin
            for (int k = 0; k < N && !v; k++) begin
                int c;
                c = (mptr[b] + k) % N;
                if (en[c] && sp[c] && int'(pr[2*c +: 2]) == b) begin
                    v = 1'b1;
                    g[c] = 1'b1;
                    if (upd) mptr[b] = (c + 1) % N;
                end
            end
        end
    endfunction

    task automatic check(input string tag, input logic [N-1:0] eg, input logic ev);
        checks++;
        if (grant !== eg || grant_valid !== ev) begin
            errors++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, grant_valid, eg, ev);
        end
    endtask

    // Drive at negedge, sample 2 ns after the next posedge.
    task automatic step(input logic [N-1:0] en, input logic [N-1:0] sp,
                        input logic [2*N-1:0] pr, input logic rq, input string tag);
        logic [N-1:0] eg;
        logic ev;
        @(negedge clk);
        ch_enable = en; ch_space_ok = sp; ch_prio = pr; req_strobe = rq;
        predict(en, sp, pr, rq, eg, ev);
        if (!rq) begin eg = '0; ev = 1'b0; end
        @(posedge clk); #2;
        check(tag, eg, ev);
    endtask

    function automatic logic [2*N-1:0] all_prio(input logic [1:0] p);
        logic [2*N-1:0] r;
        for (int c = 0; c < N; c++) r[2*c +: 2] = p;
        return r;
    endfunction

    initial begin
        logic [2*N-1:0] pr;
        for (int b = 0; b < 4; b++) mptr[b] = 0;
        #1;
        check("R1 in reset", '0, 1'b0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        check("R1 after reset", '0, 1'b0);
        // R1: first grant goes to lowest-index candidate of the bin
        step(8'b1111_0100, 8'hFF, all_prio(2'd0), 1'b1, "R1 first grant");
        // R8: nothing eligible, pointers held
        step(8'h00, 8'hFF, all_prio(2'd0), 1'b1, "R8 none enabled");
        // R4: enabled but no space / space but disabled
        step(8'hFF, 8'h00, all_prio(2'd0), 1'b1, "R4 no space");
        step(8'h0F, 8'hF0, all_prio(2'd0), 1'b1, "R4 disjoint");
        // R7: no strobe gives nothing
        step(8'hFF, 8'hFF, all_prio(2'd0), 1'b0, "R7 no strobe");
        // R5: full rotation in bin 0 with wrap
        for (int i = 0; i < 10; i++) step(8'hFF, 8'hFF, all_prio(2'd0), 1'b1, "R5 rotation");
        // R5: sparse mask rotation
        for (int i = 0; i < 4; i++) step(8'b1000_0010, 8'hFF, all_prio(2'd0), 1'b1, "R5 sparse");
        // R2/R3: each code alone, then the strict order
        for (int p = 3; p >= 0; p--) begin
            pr = all_prio(2'd3);
            pr[2*5 +: 2] = 2'(p);
            step(8'b0010_0001, 8'hFF, pr, 1'b1, "R2 code order");
        end
        pr = '0;
        for (int c = 0; c < N; c++) pr[2*c +: 2] = 2'(c % 4);
        for (int i = 0; i < 3; i++) step(8'hFF, 8'hFF, pr, 1'b1, "R3 strict");
        // R6: bin 2 pre-empted by bin 0, then returns to its own pointer
        for (int i = 0; i < 3; i++) step(8'b0100_0100, 8'hFF, pr, 1'b1, "R6 low bin alone");
        step(8'b0100_0101, 8'hFF, pr, 1'b1, "R6 preempt");
        step(8'b0100_0100, 8'hFF, pr, 1'b1, "R6 resume");
        // R9: one-hot checked with all channels competing in one bin
        step(8'hFF, 8'hFF, all_prio(2'd3), 1'b1, "R9 onehot");
        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] en, sp;
            en = N'($urandom); sp = N'($urandom) | N'($urandom);
            pr = (2*N)'({$urandom, $urandom});
            step(en, sp, pr, ($urandom % 5) != 0, "R3/R5/R6 random");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule